// File: doc/BRIEF.md
# Capture/Compare Timer Group with PWM

A group of identical 16-bit timer channels. Each channel has an up-counter and two general registers, A and B. Either register can latch the counter on a chosen edge of its capture input or compare against the counter. The counter runs free, restarts on an event from A or B (periodic mode), or advances only on rising edges of an event input. In PWM mode a channel sets its output pin on a match with A and clears it on a match with B. This gives any duty cycle from 0% to 100%.

Channels flagged as group members share two actions. A counter write to any member presets every member in the same cycle. A member whose clear source is set to group clear restarts whenever another member clears itself on its own A or B event. All configuration goes through one write port that selects a channel and a register.

Top module: `cc_timer_group`

## Requirements
- R1: After reset every counter is 0x0000, registers A and B are 0xFFFF, control is 0, and all pins and flags are 0.
- R2: Write select codes are 0 counter, 1 register A, 2 register B, 3 control. With control bit 0 (run) set and bit 3 clear, the counter adds one per clock. With run clear it holds.
- R3: The counter wraps from 0xFFFF to 0x0000 and sets its overflow flag in that step. A write to the channel's counter clears the flag.
- R4: Control bits 2:1 choose the clear source: 0 none, 1 event on A, 2 event on B, 3 group clear. A compare match happens in a counting clock where the counter equals the register. On that match the counter loads 0 instead of counting, so the period is the register value plus one.
- R5: With control bit 3 set, the counter advances once per rising edge of its event input. A level held high counts once.
- R6: Control bits 5 and 6 put A and B in capture mode. Bits 8:7 (A) and 10:9 (B) choose the edge: 0 rising, 1 falling, 2 or 3 both. On that edge the register takes the counter value and its capture flag sets. Writing the register clears the flag.
- R7: With control bit 11 set on several channels, a counter write to any one of them loads the same value into all of them at once. Channels without the bit keep counting.
- R8: A group channel with clear source 3 restarts together with any group member that clears on its own A or B event. A channel with source 3 outside the group never clears.
- R9: In PWM mode (control bit 4) the pin goes to 1 after a match with A and to 0 after a match with B. B wins when both match. Outside PWM mode the pin holds.
- R10: PWM mode makes both registers compare registers even when bits 5 or 6 request capture.
- R11: With clear on A in PWM mode, B equal to A gives a 0% pin and B above A gives a 100% pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | CHW | Channel addressed by the write |
| wr_sel_i | input | 2 | Register addressed by the write |
| wr_data_i | input | W | Write data |
| evt_i | input | NCH | External count inputs, one per channel |
| cap_a_i | input | NCH | Capture inputs for register A |
| cap_b_i | input | NCH | Capture inputs for register B |
| cnt_o | output | NCH*W | Counter values, channel 0 in the low bits |
| gra_o | output | NCH*W | Register A values |
| grb_o | output | NCH*W | Register B values |
| pin_o | output | NCH | PWM output pins |
| ovf_o | output | NCH | Overflow flags |
| capf_a_o | output | NCH | Capture flags for A |
| capf_b_o | output | NCH | Capture flags for B |

## Verification
Two pairs of functions can land on the same clock edge. The first is the A and B compare matches. The bench sets register B equal to register A in PWM mode, so both matches hit on the same count. It then judges the pin against a cycle model in which B wins, which means the pin must never rise. The second pair is the group clear and the counting of the other member. The bench checks each clock that both members restart on the same edge and stay equal.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int CTL_W = 12;

  typedef enum logic [1:0] {SEL_CNT = 2'd0, SEL_GRA = 2'd1, SEL_GRB = 2'd2, SEL_CTL = 2'd3} wsel_e;
  typedef enum logic [1:0] {CLR_NONE = 2'd0, CLR_A = 2'd1, CLR_B = 2'd2, CLR_GRP = 2'd3} clr_e;

  // bit 0 run ... bit 11 group member
  typedef struct packed {
    logic       grp;
    logic [1:0] b_edge;
    logic [1:0] a_edge;
    logic       b_cap;
    logic       a_cap;
    logic       pwm;
    logic       ext;
    clr_e       clr;
    logic       run;
  } ctl_t;

  function automatic logic edge_hit(logic [1:0] sel, logic cur, logic prev);
    case (sel)
      2'd0:    return cur & ~prev;
      2'd1:    return ~cur & prev;
      default: return cur ^ prev;
    endcase
  endfunction
endpackage

// File: rtl/cc_edge_det.sv
module cc_edge_det #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= in_i;
  end
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
  import cc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctl_we_i,
  input  logic         ga_we_i,
  input  logic         gb_we_i,
  input  logic         cnt_ld_i,
  input  logic [W-1:0] wdata_i,
  input  logic         evt_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic         grp_clr_i,
  output logic         own_clr_o,
  output logic         grp_o,
  output logic         pwm_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] ga_o,
  output logic [W-1:0] gb_o,
  output logic         pin_o,
  output logic         ovf_o,
  output logic         capf_a_o,
  output logic         capf_b_o
);
  ctl_t       ctl;
  logic [2:0] prev;
  logic       tick, match_a, match_b, cap_a_ev, cap_b_ev, do_clr;

  cc_edge_det #(.N(3)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({cap_b_i, cap_a_i, evt_i}),
    .prev_o (prev)
  );

  always_comb begin
    tick     = ctl.run & (~ctl.ext | (evt_i & ~prev[0]));
    // PWM overrides capture selection
    match_a  = tick & (ctl.pwm | ~ctl.a_cap) & (cnt_o == ga_o);
    match_b  = tick & (ctl.pwm | ~ctl.b_cap) & (cnt_o == gb_o);
    cap_a_ev = ~ctl.pwm & ctl.a_cap & edge_hit(ctl.a_edge, cap_a_i, prev[1]);
    cap_b_ev = ~ctl.pwm & ctl.b_cap & edge_hit(ctl.b_edge, cap_b_i, prev[2]);
    own_clr_o = ((ctl.clr == CLR_A) & (match_a | cap_a_ev)) |
                ((ctl.clr == CLR_B) & (match_b | cap_b_ev));
    do_clr   = own_clr_o | ((ctl.clr == CLR_GRP) & ctl.grp & grp_clr_i);
  end

  assign grp_o = ctl.grp;
  assign pwm_o = ctl.pwm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl   <= '0;
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (ctl_we_i) ctl <= ctl_t'(wdata_i[CTL_W-1:0]);
      if (cnt_ld_i) begin
        cnt_o <= wdata_i;
        ovf_o <= 1'b0;
      end else if (do_clr) begin
        cnt_o <= '0;
      end else if (tick) begin
        cnt_o <= cnt_o + W'(1);
        if (&cnt_o) ovf_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ga_o     <= '1;
      gb_o     <= '1;
      capf_a_o <= 1'b0;
      capf_b_o <= 1'b0;
    end else begin
      if (ga_we_i) begin
        ga_o     <= wdata_i;
        capf_a_o <= 1'b0;
      end else if (cap_a_ev) begin
        ga_o     <= cnt_o;
        capf_a_o <= 1'b1;
      end
      if (gb_we_i) begin
        gb_o     <= wdata_i;
        capf_b_o <= 1'b0;
      end else if (cap_b_ev) begin
        gb_o     <= cnt_o;
        capf_b_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pin_o <= 1'b0;
    else if (ctl.pwm) begin
      if (match_b)          pin_o <= 1'b0;
      else if (match_a)     pin_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cc_timer_group.sv
module cc_timer_group
  import cc_timer_pkg::*;
#(
  parameter int NCH = 3,
  parameter int W   = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CHW-1:0]   wr_ch_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [NCH-1:0]   evt_i,
  input  logic [NCH-1:0]   cap_a_i,
  input  logic [NCH-1:0]   cap_b_i,
  output logic [NCH*W-1:0] cnt_o,
  output logic [NCH*W-1:0] gra_o,
  output logic [NCH*W-1:0] grb_o,
  output logic [NCH-1:0]   pin_o,
  output logic [NCH-1:0]   ovf_o,
  output logic [NCH-1:0]   capf_a_o,
  output logic [NCH-1:0]   capf_b_o
);
  logic [NCH-1:0] own_clr, grp_en, pwm_en;
  logic           tgt_grp, grp_clr;

  always_comb begin
    tgt_grp = 1'b0;
    for (int k = 0; k < NCH; k++)
      if (32'(wr_ch_i) == k) tgt_grp = grp_en[k];
  end

  assign grp_clr = |(own_clr & grp_en);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_me, ld;
    assign sel_me = wr_en_i && (32'(wr_ch_i) == i);
    assign ld     = wr_en_i && (wr_sel_i == SEL_CNT) &&
                    ((32'(wr_ch_i) == i) || (grp_en[i] && tgt_grp));

    cc_timer_chan #(.W(W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_we_i  (sel_me && (wr_sel_i == SEL_CTL)),
      .ga_we_i   (sel_me && (wr_sel_i == SEL_GRA)),
      .gb_we_i   (sel_me && (wr_sel_i == SEL_GRB)),
      .cnt_ld_i  (ld),
      .wdata_i   (wr_data_i),
      .evt_i     (evt_i[i]),
      .cap_a_i   (cap_a_i[i]),
      .cap_b_i   (cap_b_i[i]),
      .grp_clr_i (grp_clr),
      .own_clr_o (own_clr[i]),
      .grp_o     (grp_en[i]),
      .pwm_o     (pwm_en[i]),
      .cnt_o     (cnt_o[i*W +: W]),
      .ga_o      (gra_o[i*W +: W]),
      .gb_o      (grb_o[i*W +: W]),
      .pin_o     (pin_o[i]),
      .ovf_o     (ovf_o[i]),
      .capf_a_o  (capf_a_o[i]),
      .capf_b_o  (capf_b_o[i])
    );
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int NCH = 3,
  parameter int W   = 16,
  parameter int CHW = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CHW-1:0]   wr_ch_i,
  input logic [1:0]       wr_sel_i,
  input logic [W-1:0]     wr_data_i,
  input logic [NCH*W-1:0] cnt_o,
  input logic [NCH*W-1:0] gra_o,
  input logic [NCH-1:0]   pin_o,
  input logic [NCH-1:0]   ovf_o,
  input logic [NCH-1:0]   capf_a_o,
  input logic [NCH-1:0]   pwm_en,
  input logic [NCH-1:0]   grp_en
);
  logic tgt_in_grp;
  always_comb begin
    tgt_in_grp = 1'b0;
    for (int k = 0; k < NCH; k++)
      if (32'(wr_ch_i) == k) tgt_in_grp = grp_en[k];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> (cnt_o[i*W +: W] == $past(cnt_o[i*W +: W])) ||
                   (cnt_o[i*W +: W] == $past(cnt_o[i*W +: W]) + W'(1)) ||
                   (cnt_o[i*W +: W] == '0));

    assert_ovf_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_o[i]) |-> ($past(cnt_o[i*W +: W]) == '1) && (cnt_o[i*W +: W] == '0));

    assert_cap_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(capf_a_o[i]) |-> gra_o[i*W +: W] == $past(cnt_o[i*W +: W]));

    assert_grp_preset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == 2'd0 && grp_en[i] && tgt_in_grp) |=>
        cnt_o[i*W +: W] == $past(wr_data_i));

    assert_pin_pwm_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(pin_o[i]) |-> $past(pwm_en[i]));
  end
endmodule

bind cc_timer_group cc_timer_chk #(.NCH(NCH), .W(W), .CHW(CHW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_ch_i   (wr_ch_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .cnt_o     (cnt_o),
  .gra_o     (gra_o),
  .pin_o     (pin_o),
  .ovf_o     (ovf_o),
  .capf_a_o  (capf_a_o),
  .pwm_en    (pwm_en),
  .grp_en    (grp_en)
);

// File: tb/cc_timer_group_bench.sv
module cc_timer_group_bench;
  localparam int NCH = 3;
  localparam int W   = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_en_i = 1'b0;
  logic [1:0]      wr_ch_i = '0;
  logic [1:0]      wr_sel_i = '0;
  logic [W-1:0]    wr_data_i = '0;
  logic [NCH-1:0]  evt_i = '0, cap_a_i = '0, cap_b_i = '0;
  logic [NCH*W-1:0] cnt_o, gra_o, grb_o;
  logic [NCH-1:0]  pin_o, ovf_o, capf_a_o, capf_b_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  cc_timer_group #(.NCH(NCH), .W(W)) u_cc_timer_group (
    .clk_i, .rst_ni, .wr_en_i, .wr_ch_i, .wr_sel_i, .wr_data_i,
    .evt_i, .cap_a_i, .cap_b_i, .cnt_o, .gra_o, .grb_o,
    .pin_o, .ovf_o, .capf_a_o, .capf_b_o
  );

  always #2 clk_i = ~clk_i;

  function automatic logic [W-1:0] cnt_of(int ch); return cnt_o[ch*W +: W]; endfunction
  function automatic logic [W-1:0] ga_of(int ch);  return gra_o[ch*W +: W]; endfunction
  function automatic logic [W-1:0] gb_of(int ch);  return grb_o[ch*W +: W]; endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int sel, int data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_ch_i = 2'(ch); wr_sel_i = 2'(sel); wr_data_i = W'(data);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    evt_i = '0; cap_a_i = '0; cap_b_i = '0; wr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    for (int c = 0; c < NCH; c++) begin
      check("R1 cnt", int'(cnt_of(c)), 0);
      check("R1 ga", int'(ga_of(c)), 'hFFFF);
      check("R1 gb", int'(gb_of(c)), 'hFFFF);
    end
    check("R1 pins/flags", int'({pin_o, ovf_o, capf_a_o, capf_b_o}), 0);
  endtask

  task automatic t_free();
    logic [W-1:0] v;
    do_reset();
    wr(0, 3, 'h1);
    v = cnt_of(0);
    repeat (7) @(negedge clk_i);
    check("R2 free run", int'(cnt_of(0)), int'(v + 7));
    check("R2 idle channel", int'(cnt_of(1)), 0);
    wr(0, 3, 'h0);
    v = cnt_of(0);
    repeat (5) @(negedge clk_i);
    check("R2 stopped hold", int'(cnt_of(0)), int'(v));
  endtask

  task automatic t_overflow();
    do_reset();
    wr(0, 3, 'h1);
    wr(0, 0, 'hFFFD);
    repeat (2) @(negedge clk_i);
    check("R3 at max", int'(cnt_of(0)), 'hFFFF);
    check("R3 no ovf yet", int'(ovf_o[0]), 0);
    @(negedge clk_i);
    check("R3 wrap", int'(cnt_of(0)), 0);
    check("R3 ovf set", int'(ovf_o[0]), 1);
    wr(0, 0, 'h5);
    check("R3 ovf cleared", int'(ovf_o[0]), 0);
  endtask

  task automatic t_period(int ctl, int ga, int gb, int top, string req);
    int e;
    do_reset();
    wr(0, 1, ga);
    wr(0, 2, gb);
    wr(0, 3, ctl);
    e = 0;
    check(req, int'(cnt_of(0)), e);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk_i);
      e = (e == top) ? 0 : e + 1;
      check(req, int'(cnt_of(0)), e);
    end
  endtask

  task automatic t_ext();
    logic [W-1:0] v;
    do_reset();
    wr(2, 3, 'h9);
    v = cnt_of(2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); evt_i[2] = 1'b1;
      @(negedge clk_i); evt_i[2] = 1'b0;
      @(negedge clk_i);
    end
    check("R5 three edges", int'(cnt_of(2)), int'(v + 3));
    @(negedge clk_i); evt_i[2] = 1'b1;
    repeat (6) @(negedge clk_i);
    check("R5 level counts once", int'(cnt_of(2)), int'(v + 4));
    evt_i[2] = 1'b0;
  endtask

  task automatic t_capture();
    logic [W-1:0] v;
    do_reset();
    wr(2, 3, 'h261);  // run, A rising, B falling
    repeat (3) @(negedge clk_i);
    v = cnt_of(2); cap_a_i[2] = 1'b1;
    @(negedge clk_i);
    check("R6 A rise capture", int'(ga_of(2)), int'(v));
    check("R6 A flag", int'(capf_a_o[2]), 1);
    repeat (3) @(negedge clk_i);
    cap_a_i[2] = 1'b0;
    @(negedge clk_i);
    check("R6 A fall ignored", int'(ga_of(2)), int'(v));
    cap_b_i[2] = 1'b1;
    @(negedge clk_i);
    check("R6 B rise ignored", int'(gb_of(2)), 'hFFFF);
    check("R6 B flag idle", int'(capf_b_o[2]), 0);
    repeat (2) @(negedge clk_i);
    v = cnt_of(2); cap_b_i[2] = 1'b0;
    @(negedge clk_i);
    check("R6 B fall capture", int'(gb_of(2)), int'(v));
    check("R6 B flag", int'(capf_b_o[2]), 1);
    wr(2, 1, 'h1234);
    check("R6 A write clears flag", int'(capf_a_o[2]), 0);
    check("R6 A write value", int'(ga_of(2)), 'h1234);
    wr(2, 3, 'h361);  // A both edges
    v = cnt_of(2); cap_a_i[2] = 1'b1;
    @(negedge clk_i);
    check("R6 both rise", int'(ga_of(2)), int'(v));
    @(negedge clk_i);
    v = cnt_of(2); cap_a_i[2] = 1'b0;
    @(negedge clk_i);
    check("R6 both fall", int'(ga_of(2)), int'(v));
  endtask

  task automatic t_group();
    logic [W-1:0] s2;
    int e;
    do_reset();
    wr(0, 3, 'h801);
    wr(1, 3, 'h801);
    wr(2, 3, 'h007);  // group clear source but not a member
    wr(1, 0, 'h100);
    check("R7 preset target", int'(cnt_of(1)), 'h100);
    check("R7 preset member", int'(cnt_of(0)), 'h100);
    check("R7 non-member untouched", int'(cnt_of(2) != 'h100), 1);
    wr(0, 1, 'h10);
    wr(0, 3, 'h803);
    wr(1, 3, 'h807);
    wr(0, 0, 'h0);
    s2 = cnt_of(2);
    e = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      e = (e == 'h10) ? 0 : e + 1;
      check("R8 source channel", int'(cnt_of(0)), e);
      check("R8 follower channel", int'(cnt_of(1)), e);
    end
    check("R8 outsider keeps counting", int'(cnt_of(2)), int'(s2 + 40));
  endtask

  task automatic t_pwm(int ctl, int ga, int gb, int n, string req);
    int e_cnt, e_pin;
    logic ma, mb;
    do_reset();
    wr(1, 1, ga);
    wr(1, 2, gb);
    wr(1, 3, ctl);
    e_cnt = 0; e_pin = 0;
    for (int k = 0; k < n; k++) begin
      ma = (e_cnt == ga); mb = (e_cnt == gb);
      if (mb) e_pin = 0; else if (ma) e_pin = 1;
      e_cnt = ma ? 0 : e_cnt + 1;
      @(negedge clk_i);
      check(req, int'(pin_o[1]), e_pin);
      check(req, int'(cnt_of(1)), e_cnt);
    end
  endtask

  task automatic t_pin_hold();
    logic p;
    t_pwm('h13, 5, 9, 8, "R9 set only");
    wr(1, 3, 'h1);
    p = pin_o[1];
    repeat (10) @(negedge clk_i);
    check("R9 hold outside PWM", int'(pin_o[1]), int'(p));
  endtask

  initial begin
    t_reset();
    t_free();
    t_overflow();
    t_period('h3, 4, 'hFFFF, 4, "R4 clear on A");
    t_period('h5, 'hFFFF, 3, 3, "R4 clear on B");
    t_ext();
    t_capture();
    t_group();
    t_pwm('h13, 5, 2, 20, "R9 set A clear B");
    t_pwm('h73, 5, 2, 20, "R10 capture bits overridden");
    t_pwm('h13, 5, 5, 20, "R11 zero duty, B wins");
    t_pwm('h13, 5, 7, 20, "R11 full duty");
    t_pin_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule